// File: doc/BRIEF.md
# Stagewise Multi-Mode Shifter

A purely combinational shifter. It moves a data word left or right by a count taken from a separate operand, and the width of that operand is chosen independently of the data width. Software-visible arithmetic units, address generators and normalisation paths use it to perform logical left, logical right and sign-preserving right shifts in a single cycle.

The count is applied as a chain of fixed-distance stages. Stage k moves the word by 2^k places when bit k of the count is set, and otherwise passes the word through unchanged. A left shift is not given its own chain. The word is bit-reversed before the chain and reversed again after it, so one right-moving chain serves all three shift modes. Because the count may exceed the data width, a stage whose distance reaches the full width fills the whole word.

Top module: `stagewise_shifter`

## Requirements
- R1: With mode 2'b00 (logical left) and a count below the data width, the output equals the input moved toward the MSB by the count, with zeros entering at bit 0.
- R2: With mode 2'b01 (logical right) and a count below the data width, the output equals the input moved toward bit 0 by the count, with zeros entering at the MSB.
- R3: With mode 2'b10 (arithmetic right), the positions vacated at the top are filled with copies of the input's MSB, and the output MSB always equals the input MSB.
- R4: A count equal to or larger than the data width gives all zeros in modes 2'b00 and 2'b01, and gives every bit equal to the input MSB in mode 2'b10.
- R5: Mode 2'b11 returns the input word unchanged, whatever the count.
- R6: For two counts a and b that share no set bit, a shift by a|b gives the same word as a shift by a followed by a shift by b in the same mode. A stage whose count bit is clear passes its word through untouched.
- R7: The output follows the inputs in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shf_data_i | input | W1 | Word to be shifted |
| shf_amt_i | input | W2 | Shift count, unsigned |
| shf_mode_i | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 hold |
| shf_data_o | output | W1 | Shifted word |

## Verification
The block holds no state. A fault in a stage, in the mirroring or in the fill selection therefore appears at the output in the same cycle as the input pattern that exercises it. It shows as a wrong bit at a position tied to one count bit: a stuck stage corrupts only the counts that have its bit set, and a wrong fill shows only in the top bits after a right shift of a negative word. The bench sweeps every count up to the maximum, beyond the data width, in each mode. It also checks that disjoint counts compose, so a single broken stage is exposed by the count patterns that isolate it.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SHF_LEFT   = 2'b00,
        SHF_LRIGHT = 2'b01,
        SHF_ARIGHT = 2'b10,
        SHF_HOLD   = 2'b11
    } shf_mode_e;

    // Front-end control computed once per operation
    typedef struct packed {
        logic mirror;   // reverse bit order around the right-moving chain
        logic fill;     // bit entering at the top of each stage
        logic active;   // count bits are applied
    } shf_ctrl_t;

    // Distance of stage k, clipped to the data width so that large stages
    // saturate to a complete fill instead of overflowing the index math.
    function automatic int shf_step(input int k, input int width);
        if (k >= 30) begin
            return width;
        end
        if ((1 << k) >= width) begin
            return width;
        end
        return (1 << k);
    endfunction

endpackage

// File: rtl/shf_orient.sv
module shf_orient #(
    parameter int W1 = 16
) (
    input  logic          ori_flip,
    input  logic [W1-1:0] ori_din,
    output logic [W1-1:0] ori_dout
);

    logic [W1-1:0] rev_w;

    for (genvar i = 0; i < W1; i++) begin : g_rev
        assign rev_w[i] = ori_din[W1-1-i];
    end

    always_comb begin
        ori_dout = ori_flip ? rev_w : ori_din;
    end

endmodule

// File: rtl/shf_stage.sv
module shf_stage
    import shf_pkg::*;
#(
    parameter int W1 = 16,
    parameter int K  = 0
) (
    input  logic          stg_en,
    input  logic          stg_fill,
    input  logic [W1-1:0] stg_din,
    output logic [W1-1:0] stg_dout
);

    localparam int SH = shf_step(K, W1);

    logic signed [W1:0] ext_w;

    always_comb begin
        ext_w    = $signed({stg_fill, stg_din});
        stg_dout = stg_en ? W1'(ext_w >>> SH) : stg_din;
    end

endmodule

// File: rtl/stagewise_shifter.sv
module stagewise_shifter
    import shf_pkg::*;
#(
    parameter int W1 = 16,
    parameter int W2 = 5
) (
    input  logic [W1-1:0] shf_data_i,
    input  logic [W2-1:0] shf_amt_i,
    input  logic [1:0]    shf_mode_i,
    output logic [W1-1:0] shf_data_o
);

    shf_mode_e            mode_w;
    shf_ctrl_t            ctrl_d;
    logic [W2-1:0]        amt_eff_d;
    logic [W2:0][W1-1:0]  stage_w;
    logic [W1-1:0]        oriented_w;

    always_comb begin
        mode_w        = shf_mode_e'(shf_mode_i);
        ctrl_d.mirror = (mode_w == SHF_LEFT);
        ctrl_d.fill   = (mode_w == SHF_ARIGHT) & shf_data_i[W1-1];
        ctrl_d.active = (mode_w != SHF_HOLD);
        amt_eff_d     = ctrl_d.active ? shf_amt_i : '0;
    end

    shf_orient #(.W1(W1)) u_front (
        .ori_flip (ctrl_d.mirror),
        .ori_din  (shf_data_i),
        .ori_dout (oriented_w)
    );

    assign stage_w[0] = oriented_w;

    for (genvar k = 0; k < W2; k++) begin : g_stage
        shf_stage #(.W1(W1), .K(k)) u_stage (
            .stg_en   (amt_eff_d[k]),
            .stg_fill (ctrl_d.fill),
            .stg_din  (stage_w[k]),
            .stg_dout (stage_w[k+1])
        );
    end

    shf_orient #(.W1(W1)) u_back (
        .ori_flip (ctrl_d.mirror),
        .ori_din  (stage_w[W2]),
        .ori_dout (shf_data_o)
    );

endmodule

// File: rtl/stagewise_shifter_chk.sv
module stagewise_shifter_chk #(
    parameter int W1 = 16,
    parameter int W2 = 5
) (
    input logic [W1-1:0]       chk_data,
    input logic [W2-1:0]       chk_amt,
    input logic [1:0]          chk_mode,
    input logic [W1-1:0]       chk_out,
    input logic [W2:0][W1-1:0] chk_stage
);

    logic wide_w;

    always_comb begin
        wide_w = (64'(chk_amt) >= 64'(W1));
    end

    // R5: hold mode returns the word unchanged
    always_comb begin
        if (chk_mode == 2'b11) begin
            a_r5_hold_passes: assert (chk_out == chk_data);
        end
    end

    // R3: arithmetic right keeps the sign bit
    always_comb begin
        if (chk_mode == 2'b10) begin
            a_r3_sign_kept: assert (chk_out[W1-1] == chk_data[W1-1]);
        end
    end

    // R1: a nonzero left shift brings a zero into bit 0
    always_comb begin
        if (chk_mode == 2'b00 && chk_amt != '0) begin
            a_r1_left_zero_in: assert (chk_out[0] == 1'b0);
        end
    end

    // R2: a nonzero logical right shift brings a zero into the MSB
    always_comb begin
        if (chk_mode == 2'b01 && chk_amt != '0) begin
            a_r2_right_zero_in: assert (chk_out[W1-1] == 1'b0);
        end
    end

    // R4: oversized counts saturate to a full fill
    always_comb begin
        if (wide_w && (chk_mode == 2'b00 || chk_mode == 2'b01)) begin
            a_r4_logical_flush: assert (chk_out == '0);
        end
        if (wide_w && chk_mode == 2'b10) begin
            a_r4_sign_flood: assert (chk_out == {W1{chk_data[W1-1]}});
        end
    end

    // R6: a stage whose count bit is clear leaves its word untouched
    for (genvar k = 0; k < W2; k++) begin : g_pass
        always_comb begin
            if (chk_mode != 2'b11 && !chk_amt[k]) begin
                a_r6_stage_idle: assert (chk_stage[k+1] == chk_stage[k]);
            end
        end
    end

endmodule

bind stagewise_shifter stagewise_shifter_chk #(.W1(W1), .W2(W2)) u_chk (
    .chk_data  (shf_data_i),
    .chk_amt   (shf_amt_i),
    .chk_mode  (shf_mode_i),
    .chk_out   (shf_data_o),
    .chk_stage (stage_w)
);

// File: tb/tb_stagewise_shifter.sv
module tb_stagewise_shifter;

    localparam int W1 = 16;
    localparam int W2 = 5;

    typedef struct {
        logic [W1-1:0] exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W1-1:0] data_i = '0;
    logic [W2-1:0] amt_i = '0;
    logic [1:0]    mode_i = 2'b00;
    logic [W1-1:0] data_o;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    stagewise_shifter #(.W1(W1), .W2(W2)) dut (
        .shf_data_i (data_i),
        .shf_amt_i  (amt_i),
        .shf_mode_i (mode_i),
        .shf_data_o (data_o)
    );

    function automatic logic [W1-1:0] model(input logic [W1-1:0] d,
                                            input logic [W2-1:0] a,
                                            input logic [1:0] m);
        logic [W1-1:0] r;
        case (m)
            2'b00:   r = d << a;
            2'b01:   r = d >> a;
            2'b10:   r = $signed(d) >>> a;
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [W2-1:0] a, input logic [1:0] m);
        if (m == 2'b11) return "R5";
        if (32'(a) >= W1) return "R4";
        if (m == 2'b00) return "R1";
        if (m == 2'b01) return "R2";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [W1-1:0] act, input logic [W1-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: applies one operation per cycle and records the expectation
    task automatic drive(input logic [W1-1:0] d, input logic [W2-1:0] a,
                         input logic [1:0] m, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        data_i = d;
        amt_i  = a;
        mode_i = m;
        it.exp = model(d, a, m);
        it.tag = (tag == "") ? tag_of(a, m) : tag;
        q.push_back(it);
    endtask

    // Monitor: compares results in the middle of each cycle
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(it.tag, data_o, it.exp);
            end
        end
    end

    initial begin
        int cycles = 0;
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                errors++;
                $display("FAIL watchdog actual %0d expected below 50000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R7 idle inputs", data_o, '0);
        rst = 1'b0;

        // Directed: every count in every mode on a few patterns
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < (1 << W2); a++) begin
                drive(16'h8001, W2'(a), 2'(m), "");
                drive(16'hA5C3, W2'(a), 2'(m), "");
            end
        end

        // Sign fill with positive and negative words (R3, R4)
        drive(16'h7FFF, 5'd15, 2'b10, "R3");
        drive(16'h8000, 5'd15, 2'b10, "R3");
        drive(16'h8000, 5'd16, 2'b10, "R4");
        drive(16'h4000, 5'd31, 2'b10, "R4");
        drive(16'hFFFF, 5'd16, 2'b00, "R4");
        drive(16'hFFFF, 5'd17, 2'b01, "R4");
        drive(16'h1234, 5'd31, 2'b11, "R5");

        // R6: disjoint counts compose into one shift by their OR
        for (int i = 0; i < 60; i++) begin
            logic [W1-1:0] d;
            logic [W2-1:0] a, b;
            logic [1:0]    m;
            item_t         it;
            d = W1'($urandom);
            a = W2'($urandom);
            b = W2'($urandom) & ~a;
            m = 2'($urandom_range(0, 2));
            @(posedge clk);
            #1;
            data_i = d;
            amt_i  = a | b;
            mode_i = m;
            it.exp = model(model(d, a, m), b, m);
            it.tag = "R6";
            q.push_back(it);
        end

        // Random sweep, including oversized counts
        for (int i = 0; i < 400; i++) begin
            drive(W1'($urandom), W2'($urandom), 2'($urandom), "");
        end

        // R7: output settles with no clock edge in between
        for (int i = 0; i < 20; i++) begin
            logic [W1-1:0] d;
            logic [W2-1:0] a;
            logic [1:0]    m;
            @(negedge clk);
            d = W1'($urandom);
            a = W2'($urandom);
            m = 2'($urandom);
            #1;
            data_i = d;
            amt_i  = a;
            mode_i = m;
            #1;
            check("R7", data_o, model(d, a, m));
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule